// File: doc/BRIEF.md
# DMA Channel Enable and Completion Control

This block is the control half of a single DMA channel. It holds the channel's enable, interrupt-enable and end-of-transfer flags together with a down-counting transfer count, and decides in every cycle whether the channel may ask the datapath for another transfer unit. The datapath is not part of this block. A single-cycle acknowledge input, `xfer_done`, stands in for it and marks each transfer unit as carried out.

A request can come from one of three sources. In auto mode the channel asks for work on its own. The other two sources are an external request line and an on-chip peripheral request line. For either line, only a rising edge seen while the channel is open starts a unit. The end flag is raised only when the count runs down to zero. A stop for any other reason leaves it clear. Software can clear the flag only by first reading it as 1 and then writing 0 to it. Four conditions besides the local enable gate the channel at once: the end flag, a global master enable, an NMI flag and an address-error flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: After a synchronous reset, the enable, interrupt-enable and end flags read 0, the count reads 0, and both `xfer_req` and `end_irq` are 0.
- R2: Address 0 is the control word, with bit 0 = channel enable, bit 1 = end flag and bit 2 = interrupt enable. Address 1 is the count, zero-extended. `reg_rdata` shows the addressed register combinationally, and addresses 2 and 3 read 0.
- R3: Each accepted transfer unit (`xfer_done` while `xfer_req` is 1) lowers the count by one at the next clock edge. A count write in the same cycle takes priority over the decrement.
- R4: When an accepted unit takes the count from 1 to 0, the end flag becomes 1 at that clock edge. `end_irq` is the level (end flag AND interrupt enable).
- R5: If the channel is stopped by the NMI flag, the address-error flag, a low master enable or a cleared enable bit, `xfer_req` drops in that same cycle. While stopped, `xfer_done` changes neither the count nor the end flag, and the end flag stays 0.
- R6: A write of 0 to the end flag clears it only when a read of address 0 (`reg_rd`) has returned the flag as 1 since it was last set. A write of 0 without such a read leaves it at 1. Writing 1 to the flag never sets it.
- R7: `xfer_req` can be 1 only while all of these hold: enable is 1, the end flag is 0, `dma_master_en` is 1, `nmi_flag` is 0 and `addr_err` is 0. Setting enable while the end flag is 1 starts nothing.
- R8: With `req_mode` = 0 (auto), `xfer_req` is 1 in the cycle after the enabling write, provided the channel is open and the count is nonzero.
- R9: With `req_mode` = 1 (external, `req_ext`) or 2 (peripheral, `req_mod`), only a 0-to-1 change of the selected line while the channel is open sets a pending request, and `xfer_req` rises after that clock edge. A line already high when enable is set, an edge while the channel is closed, and an edge on the line that is not selected all start nothing. `req_mode` = 3 never requests.
- R10: In the edge-triggered modes, an accepted unit consumes the pending request, so each unit needs a new edge.
- R11: With a count of 0, `xfer_req` stays 0 even when the channel is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or manual) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the end-flag clear) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| req_mode | input | 2 | Request source: 0 auto, 1 external, 2 peripheral, 3 none |
| req_ext | input | 1 | External request line |
| req_mod | input | 1 | On-chip peripheral request line |
| dma_master_en | input | 1 | Global DMA enable |
| nmi_flag | input | 1 | NMI stop flag |
| addr_err | input | 1 | Address-error stop flag |
| xfer_done | input | 1 | Datapath acknowledge: one unit transferred |
| xfer_req | output | 1 | Channel asks for a transfer unit |
| end_irq | output | 1 | Transfer-end interrupt level |

## Verification
The hardest state to reach is one where the end flag and a stop condition interact. Examples are a channel re-enabled while the flag is still set, a request line that was already high before enable, and a done strobe that arrives while the channel is stopped. The stimulus reaches each of these by running a full count to raise the end flag. It then writes to the control word without the arming read, reloads the count, and only later performs the read-then-clear sequence. For each stop source it holds `xfer_done` high while that source is active and reads back the count and the flag through the register port.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;

    localparam int BIT_EN = 0;
    localparam int BIT_TE = 1;
    localparam int BIT_IE = 2;
    localparam int CTRL_BITS = 3;

    typedef enum logic [1:0] {
        SRC_AUTO   = 2'd0,
        SRC_EXT    = 2'd1,
        SRC_PERIPH = 2'd2,
        SRC_NONE   = 2'd3
    } req_src_e;

    typedef struct packed {
        logic ie;
        logic te;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic gen;
        logic nmi;
        logic aerr;
    } master_t;

    // channel may run only when every gate is open
    function automatic logic gate_open(ctrl_t c, master_t m);
        return c.en && !c.te && m.gen && !m.nmi && !m.aerr;
    endfunction

endpackage

// File: rtl/dch_count.sv
module dch_count
    import dmach_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          nz,
    output logic          te_set
);

    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign nz     = (cnt != '0);
    assign te_set = dec && !load && (cnt == ONE);

    assert_dec_step_R3: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - ONE));

    assert_no_dec_at_zero_R11: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));

endmodule

// File: rtl/dch_regs.sv
module dch_regs
    import dmach_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 rd,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_BITS-1:0] wbits,
    input  logic                 te_set,
    input  logic [CW-1:0]        cnt,
    output ctrl_t                ctrl,
    output logic [DW-1:0]        rdata
);

    logic seen_one;
    logic wr_ctrl;
    logic rd_ctrl;
    logic clr_req;

    assign wr_ctrl = wr && (addr == A_CTRL);
    assign rd_ctrl = rd && (addr == A_CTRL);
    assign clr_req = wr_ctrl && !wbits[BIT_TE] && seen_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            seen_one <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en <= wbits[BIT_EN];
                ctrl.ie <= wbits[BIT_IE];
            end
            if (te_set) begin
                ctrl.te  <= 1'b1;
                seen_one <= 1'b0;
            end else if (clr_req) begin
                ctrl.te  <= 1'b0;
                seen_one <= 1'b0;
            end else if (rd_ctrl && ctrl.te) begin
                seen_one <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[BIT_EN] = ctrl.en;
                rdata[BIT_TE] = ctrl.te;
                rdata[BIT_IE] = ctrl.ie;
            end
            A_COUNT: rdata = DW'(cnt);
            default: rdata = '0;
        endcase
    end

    assert_te_only_normal_end_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.te) |-> $past(te_set));

    assert_te_clear_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.te) |-> $past(wr_ctrl && !wbits[BIT_TE] && seen_one));

endmodule

// File: rtl/dch_req.sv
module dch_req
    import dmach_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       req_ext,
    input  logic       req_mod,
    input  logic       open,
    input  logic       nz,
    input  logic       done,
    output logic       xfer_req,
    output logic       dec
);

    req_src_e src;
    logic     sel;
    logic     sel_q;
    logic     rq_edge;
    logic     pending;

    assign src = req_src_e'(mode);

    always_comb begin
        case (src)
            SRC_EXT:    sel = req_ext;
            SRC_PERIPH: sel = req_mod;
            default:    sel = 1'b0;
        endcase
    end

    assign rq_edge = sel && !sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= 1'b0;
            pending <= 1'b0;
        end else begin
            sel_q <= sel;
            if (!open) begin
                pending <= 1'b0;
            end else if (rq_edge) begin
                pending <= 1'b1;
            end else if (dec) begin
                pending <= 1'b0;
            end
        end
    end

    always_comb begin
        case (src)
            SRC_AUTO:             xfer_req = open && nz;
            SRC_EXT, SRC_PERIPH:  xfer_req = open && nz && pending;
            default:              xfer_req = 1'b0;
        endcase
    end

    assign dec = done && xfer_req;

    assert_pending_from_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> $past(open && sel && !sel_q));

    assert_unit_consumes_R10: assert property (@(posedge clk) disable iff (rst)
        (dec && !rq_edge) |=> !pending);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dmach_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [1:0]        req_mode,
    input  logic              req_ext,
    input  logic              req_mod,
    input  logic              dma_master_en,
    input  logic              nmi_flag,
    input  logic              addr_err,
    input  logic              xfer_done,
    output logic              xfer_req,
    output logic              end_irq
);

    ctrl_t         ctrl_q;
    master_t       mst;
    logic          chan_open;
    logic          cnt_nz;
    logic          te_set;
    logic          dec;
    logic          cnt_load;
    logic [CW-1:0] cnt;

    assign mst       = '{gen: dma_master_en, nmi: nmi_flag, aerr: addr_err};
    assign chan_open = gate_open(ctrl_q, mst);
    assign cnt_load  = reg_wr && (reg_addr == A_COUNT);
    assign end_irq   = ctrl_q.te && ctrl_q.ie;

    dch_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wbits  (reg_wdata[CTRL_BITS-1:0]),
        .te_set (te_set),
        .cnt    (cnt),
        .ctrl   (ctrl_q),
        .rdata  (reg_rdata)
    );

    dch_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (reg_wdata[CW-1:0]),
        .dec      (dec),
        .cnt      (cnt),
        .nz       (cnt_nz),
        .te_set   (te_set)
    );

    dch_req u_req (
        .clk      (clk),
        .rst      (rst),
        .mode     (req_mode),
        .req_ext  (req_ext),
        .req_mod  (req_mod),
        .open     (chan_open),
        .nz       (cnt_nz),
        .done     (xfer_done),
        .xfer_req (xfer_req),
        .dec      (dec)
    );

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> (dma_master_en && !nmi_flag && !addr_err && !ctrl_q.te));

    assert_stop_holds_count_R5: assert property (@(posedge clk) disable iff (rst)
        (!xfer_req && !cnt_load) |=> (cnt == $past(cnt)));

endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;

    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [1:0]    req_mode = 2'd0;
    logic          req_ext = 1'b0;
    logic          req_mod = 1'b0;
    logic          dma_master_en = 1'b1;
    logic          nmi_flag = 1'b0;
    logic          addr_err = 1'b0;
    logic          xfer_done = 1'b0;
    logic          xfer_req;
    logic          end_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_chan_ctl #(.DW(DW), .CW(CW)) i_dma_chan_ctl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_mode(req_mode), .req_ext(req_ext), .req_mod(req_mod),
        .dma_master_en(dma_master_en), .nmi_flag(nmi_flag), .addr_err(addr_err),
        .xfer_done(xfer_done), .xfer_req(xfer_req), .end_irq(end_irq)
    );

    // vector: {mode[1:0], count[7:0], ie}
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {2'd0, 8'd3, 1'b1},
        {2'd1, 8'd2, 1'b0},
        {2'd2, 8'd4, 1'b1},
        {2'd0, 8'd1, 1'b0},
        {2'd1, 8'd1, 1'b1},
        {2'd2, 8'd2, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] cw(input logic en, input logic te, input logic ie);
        return DW'({ie, te, en});
    endfunction

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic rd_ctrl(output logic [DW-1:0] d);
        reg_rd = 1'b1; reg_addr = 2'd0; #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic pulse_line(input logic [1:0] m);
        if (m == 2'd1) req_ext = 1'b1; else req_mod = 1'b1;
        @(negedge clk);
        req_ext = 1'b0; req_mod = 1'b0;
        #1;
    endtask

    task automatic clear_te(input logic en);
        logic [DW-1:0] d;
        rd_ctrl(d);
        wr(2'd0, cw(en, 1'b0, 1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        peek(2'd0, d); chk("R1 ctrl after reset", d, 0);
        peek(2'd1, d); chk("R1 count after reset", d, 0);
        chk("R1 xfer_req after reset", xfer_req, 0);
        chk("R1 end_irq after reset", end_irq, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] m;
            logic [7:0] c;
            logic       ie;
            {m, c, ie} = VEC[i];
            req_mode = m;
            wr(2'd1, DW'(c));
            wr(2'd0, cw(1'b1, 1'b0, ie));
            #1;
            if (m == 2'd0) chk("R8 auto request after enable", xfer_req, 1);
            else           chk("R9 no request before edge", xfer_req, 0);
            for (int k = 0; k < int'(c); k++) begin
                if (m != 2'd0) begin
                    pulse_line(m);
                    chk("R9 edge starts unit", xfer_req, 1);
                end
                pulse_done();
                peek(2'd1, d);
                chk("R3 count after unit", d, 32'(c) - 32'(k) - 1);
            end
            peek(2'd0, d);
            chk("R4 end flag after count ends", d[1], 1);
            chk("R4 irq level equals ie", end_irq, ie);
            chk("R11 no request at zero", xfer_req, 0);
            clear_te(1'b0);
            peek(2'd0, d);
            chk("R6 cleared after read then write 0", d[1], 0);
            chk("R4 irq follows flag", end_irq, 0);
        end

        // R6 and R7: write 0 without read, enable while flag set
        req_mode = 2'd0;
        wr(2'd1, 16'd1);
        wr(2'd0, cw(1'b1, 1'b0, 1'b1));
        pulse_done();
        wr(2'd0, cw(1'b1, 1'b0, 1'b1));
        peek(2'd0, d);
        chk("R6 write 0 without read keeps flag", d[1], 1);
        wr(2'd1, 16'd5);
        #1;
        chk("R7 enable with flag set starts nothing", xfer_req, 0);
        pulse_done();
        peek(2'd1, d);
        chk("R7 count held while flag set", d, 5);
        clear_te(1'b0);
        wr(2'd0, cw(1'b0, 1'b1, 1'b0));
        peek(2'd0, d);
        chk("R6 writing 1 does not set flag", d[1], 0);

        // R2 map and unmapped reads
        peek(2'd2, d); chk("R2 unmapped reads 0", d, 0);
        peek(2'd3, d); chk("R2 unmapped reads 0 (3)", d, 0);
        wr(2'd0, cw(1'b0, 1'b0, 1'b1));
        peek(2'd0, d); chk("R2 ie at bit 2", d, 16'h4);

        // R5 abnormal stops, auto mode, count 5
        wr(2'd0, cw(1'b1, 1'b0, 1'b1));
        #1; chk("R8 auto running", xfer_req, 1);
        nmi_flag = 1'b1; #1;
        chk("R5 nmi drops request", xfer_req, 0);
        pulse_done(); nmi_flag = 1'b0;
        peek(2'd1, d); chk("R5 count held on nmi", d, 5);
        addr_err = 1'b1; #1;
        chk("R5 address error drops request", xfer_req, 0);
        pulse_done(); addr_err = 1'b0;
        peek(2'd1, d); chk("R5 count held on address error", d, 5);
        dma_master_en = 1'b0; #1;
        chk("R5 master off drops request", xfer_req, 0);
        pulse_done(); dma_master_en = 1'b1;
        peek(2'd1, d); chk("R5 count held master off", d, 5);
        wr(2'd0, cw(1'b0, 1'b0, 1'b1));
        #1; chk("R5 enable clear drops request", xfer_req, 0);
        pulse_done();
        peek(2'd0, d); chk("R5 flag stays 0 after stops", d[1], 0);
        chk("R5 irq stays 0 after stops", end_irq, 0);

        // R3 load priority over decrement
        wr(2'd0, cw(1'b1, 1'b0, 1'b0));
        xfer_done = 1'b1;
        wr(2'd1, 16'd7);
        xfer_done = 1'b0;
        peek(2'd1, d); chk("R3 write beats decrement", d, 7);

        // R9 stale level, edge while closed, wrong line
        wr(2'd0, cw(1'b0, 1'b0, 1'b0));
        req_mode = 2'd1;
        req_ext = 1'b1;
        @(negedge clk);
        wr(2'd0, cw(1'b1, 1'b0, 1'b0));
        repeat (2) @(negedge clk);
        chk("R9 level held before enable ignored", xfer_req, 0);
        req_ext = 1'b0;
        @(negedge clk);
        dma_master_en = 1'b0;
        pulse_line(2'd1);
        dma_master_en = 1'b1;
        @(negedge clk);
        chk("R9 edge while closed not queued", xfer_req, 0);
        pulse_line(2'd2);
        chk("R9 unselected line ignored", xfer_req, 0);
        req_mode = 2'd3;
        pulse_line(2'd1);
        chk("R9 mode 3 never requests", xfer_req, 0);

        // R10 one edge, one unit
        req_mode = 2'd1;
        @(negedge clk);
        pulse_line(2'd1);
        chk("R9 edge starts unit again", xfer_req, 1);
        pulse_done();
        chk("R10 request consumed", xfer_req, 0);
        pulse_done();
        peek(2'd1, d); chk("R10 second done ignored", d, 6);

        // R11 zero count with open channel
        req_mode = 2'd0;
        wr(2'd1, 16'd0);
        #1; chk("R11 zero count no request", xfer_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule